// File: doc/BRIEF.md
# Drive Status and Command Frame Unit

This block sits between a CD drive controller and the sub-processor. It handles two frames of ten 4-bit nibbles each. The outgoing status frame is built from the drive's current status byte and its minute, second and frame position bytes, plus a 4-bit extension value. A checksum nibble closes the frame. The incoming command frame is written by the host one nibble at a time. When the host imports it, the block decodes the command code, and for a table-of-contents query it also decodes the sub-command.

The drive state machine asserts an export strobe, and the block registers a new status frame. On the same edge it trims the host control register and, if the mask allows it, raises a one-cycle interrupt. On an import strobe the block presents the decoded command with a valid pulse. A table-of-contents query also rewrites the low nibble of the held status byte. Mechanics, seeking, table storage and audio playback are handled elsewhere.

Top module: `cdif_frame_unit`

## Requirements
- R1: After reset the status frame reads zero in nibbles 0 to 8 and 0xF in nibble 9. The held status byte, control register, interrupt output, command valid and decoded code are all zero.
- R2: When `exp_stb` is high at a clock edge, `stat_frame` shows the new frame after that edge. Nibble i sits at bits [4i+3:4i]. Nibbles 0 and 1 are the high and low nibbles of the held status byte. Nibbles 2 and 3 are minute high and low, 4 and 5 are second high and low, 6 and 7 are frame high and low, and nibble 8 is the extension.
- R3: Nibble 9 is the bitwise inverse of the 4-bit truncated sum of nibbles 0 to 8.
- R4: An export leaves only bits 1:0 of the control register. A control write in the same cycle is masked the same way.
- R5: `irq_req` is high for exactly the one cycle after an export, and only when `irq_mask` bit 4 was set. Otherwise it stays low.
- R6: One cycle after `imp_stb`, `cmd_valid` pulses for one cycle. `cmd_code` takes nibble 0 of the stored command frame for codes 0, 1, 3, 4, 6, 7, 8, 9, 0xA, 0xC and 0xD.
- R7: A code of 2 with sub-command nibble 3 in the range 0 to 5 decodes as code 2. `toc_sub` then equals that sub-command. The low nibble of the held status byte becomes the sub-command and the high nibble is kept.
- R8: A code of 2 with sub-command above 5 decodes as code 0, the plain status report. The status low nibble becomes 0xF.
- R9: Codes 5, 0xB, 0xE and 0xF decode as 0xF (unknown) and leave the held status byte unchanged.
- R10: A drive status load (`drv_stat_ld`) and a query import in the same cycle give the high nibble from the load and the low nibble from the query. Without a query, the load sets the whole byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| drv_stat_ld | input | 1 | Load held status byte from `drv_stat` |
| drv_stat | input | 8 | Status byte from the drive state machine |
| drv_min | input | 8 | Minute byte |
| drv_sec | input | 8 | Second byte |
| drv_frm | input | 8 | Frame byte |
| drv_ext | input | 4 | Extension nibble |
| exp_stb | input | 1 | Export strobe, one cycle |
| irq_mask | input | 8 | Interrupt mask register, bit 4 gates the export interrupt |
| ctrl_wr | input | 1 | Host control register write enable |
| ctrl_wdata | input | 8 | Host control write data |
| cmd_wr | input | 1 | Command nibble write enable |
| cmd_idx | input | 4 | Command nibble index, 0 to 9 |
| cmd_nib | input | 4 | Command nibble data |
| imp_stb | input | 1 | Command import strobe, one cycle |
| stat_frame | output | 40 | Registered status frame |
| ctrl_reg | output | 8 | Host control register |
| irq_req | output | 1 | One-cycle interrupt request |
| cmd_code | output | 4 | Decoded command code |
| cmd_valid | output | 1 | Decoded command valid pulse |
| toc_sub | output | 4 | Sub-command nibble of the last import |

## Verification
Some properties are checked on every cycle. The checksum always closes the frame to 0xF, and the interrupt only follows a masked-in export. The valid pulse only follows an import, and a decoded query never carries a sub-command above 5. The control register's upper bits are clear after an export, and the status high nibble is kept across an import without a load. Other behaviour is shown only by bench scenarios. These are the exact nibble placement of the drive bytes, the command mapping for all sixteen codes, and the status byte rewrite by queries. They also cover the same-cycle collisions of a load with a query and of a control write with an export.

// File: rtl/cdif_pkg.sv
package cdif_pkg;
  localparam int NIB_W = 4;

  typedef enum logic [3:0] {
    CMD_STATUS  = 4'h0,
    CMD_STOP    = 4'h1,
    CMD_TOC     = 4'h2,
    CMD_READ    = 4'h3,
    CMD_SEEK    = 4'h4,
    CMD_PAUSE   = 4'h6,
    CMD_RESUME  = 4'h7,
    CMD_FFWD    = 4'h8,
    CMD_REWIND  = 4'h9,
    CMD_INIT    = 4'hA,
    CMD_CLOSE   = 4'hC,
    CMD_OPEN    = 4'hD,
    CMD_UNKNOWN = 4'hF
  } cmd_e;
endpackage

// File: rtl/cdif_cmd_window.sv
module cdif_cmd_window
  import cdif_pkg::*;
#(
  parameter int FRAME_NIBS = 10,
  parameter int SUB_MAX    = 5,
  parameter int CODE_POS   = 0,
  parameter int SUB_POS    = 3,
  localparam int IDX_W     = $clog2(FRAME_NIBS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [NIB_W-1:0] wr_nib,
  input  logic             imp_stb,
  output logic             toc_apply,
  output logic [NIB_W-1:0] toc_lo,
  output cmd_e             cmd_o,
  output logic             valid_o,
  output logic [NIB_W-1:0] sub_o
);
  logic [NIB_W-1:0] nib_q [FRAME_NIBS];

  for (genvar g = 0; g < FRAME_NIBS; g++) begin : g_nib
    logic hit;
    assign hit = wr_en && (wr_idx == IDX_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   nib_q[g] <= '0;
      else if (hit) nib_q[g] <= wr_nib;
    end
  end

  logic [NIB_W-1:0] code_n, sub_n;
  logic             sub_ok;
  cmd_e             dec;

  assign code_n = nib_q[CODE_POS];
  assign sub_n  = nib_q[SUB_POS];
  assign sub_ok = (sub_n <= NIB_W'(SUB_MAX));

  always_comb begin
    case (code_n)
      4'h0, 4'h1, 4'h3, 4'h4, 4'h6, 4'h7,
      4'h8, 4'h9, 4'hA, 4'hC, 4'hD: dec = cmd_e'(code_n);
      4'h2:                         dec = sub_ok ? CMD_TOC : CMD_STATUS;
      default:                      dec = CMD_UNKNOWN;
    endcase
  end

  assign toc_apply = imp_stb && (code_n == 4'h2);
  assign toc_lo    = sub_ok ? sub_n : '1;

  cmd_e             cmd_d;
  logic             valid_d;
  logic [NIB_W-1:0] sub_d;

  always_comb begin
    cmd_d   = cmd_o;
    sub_d   = sub_o;
    valid_d = imp_stb;
    if (imp_stb) begin
      cmd_d = dec;
      sub_d = sub_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_o   <= CMD_STATUS;
      valid_o <= 1'b0;
      sub_o   <= '0;
    end else begin
      cmd_o   <= cmd_d;
      valid_o <= valid_d;
      sub_o   <= sub_d;
    end
  end

  AST_VALID_AFTER_IMPORT: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> $past(imp_stb)); // R6
  AST_TOC_SUB_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && cmd_o == CMD_TOC) |-> (sub_o <= NIB_W'(SUB_MAX))); // R7
endmodule

// File: rtl/cdif_stat_export.sv
module cdif_stat_export
  import cdif_pkg::*;
#(
  parameter int FRAME_NIBS = 10,
  parameter int IRQ_BIT    = 4,
  parameter int MASK_W     = 8,
  localparam int BODY_W    = (FRAME_NIBS - 1) * NIB_W,
  localparam int FRAME_W   = FRAME_NIBS * NIB_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               exp_stb,
  input  logic [BODY_W-1:0]  body_i,
  input  logic [MASK_W-1:0]  mask_i,
  output logic [FRAME_W-1:0] frame_o,
  output logic               irq_o
);
  function automatic logic [NIB_W-1:0] nib_sum(input logic [BODY_W-1:0] b);
    logic [NIB_W-1:0] s;
    s = '0;
    for (int i = 0; i < FRAME_NIBS - 1; i++) s = s + b[i*NIB_W +: NIB_W];
    return s;
  endfunction

  logic [FRAME_W-1:0] frame_d;
  logic               irq_d;

  always_comb begin
    frame_d = frame_o;
    if (exp_stb) frame_d = {~nib_sum(body_i), body_i};
    irq_d = exp_stb && mask_i[IRQ_BIT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_o <= {{NIB_W{1'b1}}, {BODY_W{1'b0}}};
      irq_o   <= 1'b0;
    end else begin
      frame_o <= frame_d;
      irq_o   <= irq_d;
    end
  end

  function automatic logic [NIB_W-1:0] full_sum(input logic [FRAME_W-1:0] f);
    logic [NIB_W-1:0] s;
    s = '0;
    for (int i = 0; i < FRAME_NIBS; i++) s = s + f[i*NIB_W +: NIB_W];
    return s;
  endfunction

  AST_CSUM_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    full_sum(frame_o) == {NIB_W{1'b1}}); // R3
  AST_IRQ_FROM_EXPORT: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> $past(exp_stb && mask_i[IRQ_BIT])); // R5
  AST_EXPORT_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (exp_stb && mask_i[IRQ_BIT]) |=> irq_o); // R5
endmodule

// File: rtl/cdif_frame_unit.sv
module cdif_frame_unit
  import cdif_pkg::*;
#(
  parameter int FRAME_NIBS = 10,
  parameter int SUB_MAX    = 5,
  parameter int IRQ_BIT    = 4,
  parameter int CTRL_KEEP  = 2,
  localparam int BYTE_W    = 2 * NIB_W,
  localparam int IDX_W     = $clog2(FRAME_NIBS),
  localparam int FRAME_W   = FRAME_NIBS * NIB_W,
  localparam int BODY_W    = (FRAME_NIBS - 1) * NIB_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               drv_stat_ld,
  input  logic [BYTE_W-1:0]  drv_stat,
  input  logic [BYTE_W-1:0]  drv_min,
  input  logic [BYTE_W-1:0]  drv_sec,
  input  logic [BYTE_W-1:0]  drv_frm,
  input  logic [NIB_W-1:0]   drv_ext,
  input  logic               exp_stb,
  input  logic [BYTE_W-1:0]  irq_mask,
  input  logic               ctrl_wr,
  input  logic [BYTE_W-1:0]  ctrl_wdata,
  input  logic               cmd_wr,
  input  logic [IDX_W-1:0]   cmd_idx,
  input  logic [NIB_W-1:0]   cmd_nib,
  input  logic               imp_stb,
  output logic [FRAME_W-1:0] stat_frame,
  output logic [BYTE_W-1:0]  ctrl_reg,
  output logic               irq_req,
  output logic [NIB_W-1:0]   cmd_code,
  output logic               cmd_valid,
  output logic [NIB_W-1:0]   toc_sub
);
  localparam logic [BYTE_W-1:0] CTRL_MASK = BYTE_W'((1 << CTRL_KEEP) - 1);

  logic             toc_apply;
  logic [NIB_W-1:0] toc_lo;
  cmd_e             dec_cmd;

  cdif_cmd_window #(
    .FRAME_NIBS (FRAME_NIBS),
    .SUB_MAX    (SUB_MAX)
  ) i_cmd (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (cmd_wr),
    .wr_idx    (cmd_idx),
    .wr_nib    (cmd_nib),
    .imp_stb   (imp_stb),
    .toc_apply (toc_apply),
    .toc_lo    (toc_lo),
    .cmd_o     (dec_cmd),
    .valid_o   (cmd_valid),
    .sub_o     (toc_sub)
  );
  assign cmd_code = dec_cmd;

  // held status byte
  logic [BYTE_W-1:0] stat_q, stat_d;
  always_comb begin
    stat_d = stat_q;
    if (drv_stat_ld) stat_d = drv_stat;
    if (toc_apply)   stat_d[NIB_W-1:0] = toc_lo;
  end

  // host control register
  logic [BYTE_W-1:0] ctrl_d;
  always_comb begin
    ctrl_d = ctrl_reg;
    if (ctrl_wr) ctrl_d = ctrl_wdata;
    if (exp_stb) ctrl_d = ctrl_d & CTRL_MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q   <= '0;
      ctrl_reg <= '0;
    end else begin
      stat_q   <= stat_d;
      ctrl_reg <= ctrl_d;
    end
  end

  logic [BODY_W-1:0] body;
  assign body = {drv_ext,
                 drv_frm[NIB_W-1:0], drv_frm[BYTE_W-1:NIB_W],
                 drv_sec[NIB_W-1:0], drv_sec[BYTE_W-1:NIB_W],
                 drv_min[NIB_W-1:0], drv_min[BYTE_W-1:NIB_W],
                 stat_q[NIB_W-1:0],  stat_q[BYTE_W-1:NIB_W]};

  cdif_stat_export #(
    .FRAME_NIBS (FRAME_NIBS),
    .IRQ_BIT    (IRQ_BIT),
    .MASK_W     (BYTE_W)
  ) i_exp (
    .clk     (clk),
    .rst_n   (rst_n),
    .exp_stb (exp_stb),
    .body_i  (body),
    .mask_i  (irq_mask),
    .frame_o (stat_frame),
    .irq_o   (irq_req)
  );

  AST_CTRL_TRIMMED: assert property (@(posedge clk) disable iff (!rst_n)
    exp_stb |=> ((ctrl_reg & ~CTRL_MASK) == '0)); // R4
  AST_STAT_HI_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (imp_stb && !drv_stat_ld) |=> $stable(stat_q[BYTE_W-1:NIB_W])); // R7
endmodule

// File: tb/test_cdif_frame_unit.sv
module test_cdif_frame_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        drv_stat_ld;
  logic [7:0]  drv_stat, drv_min, drv_sec, drv_frm;
  logic [3:0]  drv_ext;
  logic        exp_stb;
  logic [7:0]  irq_mask;
  logic        ctrl_wr;
  logic [7:0]  ctrl_wdata;
  logic        cmd_wr;
  logic [3:0]  cmd_idx, cmd_nib;
  logic        imp_stb;
  logic [39:0] stat_frame;
  logic [7:0]  ctrl_reg;
  logic        irq_req;
  logic [3:0]  cmd_code;
  logic        cmd_valid;
  logic [3:0]  toc_sub;

  int vecs = 0;
  int errs = 0;
  logic [7:0] stat_m;
  logic [7:0] ctrl_m;
  bit done = 0;

  always #5 clk = ~clk;

  cdif_frame_unit i_cdif_frame_unit (
    .clk(clk), .rst_n(rst_n), .drv_stat_ld(drv_stat_ld), .drv_stat(drv_stat),
    .drv_min(drv_min), .drv_sec(drv_sec), .drv_frm(drv_frm), .drv_ext(drv_ext),
    .exp_stb(exp_stb), .irq_mask(irq_mask), .ctrl_wr(ctrl_wr),
    .ctrl_wdata(ctrl_wdata), .cmd_wr(cmd_wr), .cmd_idx(cmd_idx),
    .cmd_nib(cmd_nib), .imp_stb(imp_stb), .stat_frame(stat_frame),
    .ctrl_reg(ctrl_reg), .irq_req(irq_req), .cmd_code(cmd_code),
    .cmd_valid(cmd_valid), .toc_sub(toc_sub)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    vecs++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [39:0] exp_frame(input logic [7:0] s, input logic [7:0] m,
      input logic [7:0] sc, input logic [7:0] f, input logic [3:0] e);
    logic [35:0] b;
    logic [3:0]  sum;
    b = {e, f[3:0], f[7:4], sc[3:0], sc[7:4], m[3:0], m[7:4], s[3:0], s[7:4]};
    sum = 4'h0;
    for (int i = 0; i < 9; i++) sum = sum + b[i*4 +: 4];
    return {~sum, b};
  endfunction

  function automatic logic [3:0] exp_code(input logic [3:0] c, input logic [3:0] s);
    case (c)
      4'h0, 4'h1, 4'h3, 4'h4, 4'h6, 4'h7, 4'h8, 4'h9, 4'hA, 4'hC, 4'hD: return c;
      4'h2: return (s <= 4'd5) ? 4'h2 : 4'h0;
      default: return 4'hF;
    endcase
  endfunction

  task automatic do_export(input bit mask4, input bit wr, input logic [7:0] wv);
    logic [39:0] ef;
    @(negedge clk);
    drv_min = 8'($urandom); drv_sec = 8'($urandom);
    drv_frm = 8'($urandom); drv_ext = 4'($urandom);
    irq_mask = 8'($urandom); irq_mask[4] = mask4;
    ctrl_wr = wr; ctrl_wdata = wv;
    exp_stb = 1'b1;
    ef = exp_frame(stat_m, drv_min, drv_sec, drv_frm, drv_ext);
    ctrl_m = (wr ? wv : ctrl_m) & 8'h03;
    @(negedge clk);
    exp_stb = 1'b0; ctrl_wr = 1'b0;
    chk(stat_frame == ef, "R2/R3 frame", stat_frame, ef);
    chk(ctrl_reg == ctrl_m, "R4 ctrl", ctrl_reg, ctrl_m);
    chk(irq_req == mask4, "R5 irq", irq_req, mask4);
    @(negedge clk);
    chk(irq_req == 1'b0, "R5 irq one cycle", irq_req, 0);
  endtask

  task automatic do_command(input logic [3:0] code, input logic [3:0] sub,
                            input bit ld, input logic [7:0] ldv);
    logic [3:0] ec;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      cmd_wr = 1'b1; cmd_idx = 4'(i);
      cmd_nib = (i == 0) ? code : (i == 3) ? sub : 4'($urandom);
    end
    @(negedge clk);
    cmd_wr = 1'b0; imp_stb = 1'b1;
    drv_stat_ld = ld; drv_stat = ldv;
    if (ld) stat_m = ldv;
    if (code == 4'h2) stat_m[3:0] = (sub <= 4'd5) ? sub : 4'hF;
    ec = exp_code(code, sub);
    @(negedge clk);
    imp_stb = 1'b0; drv_stat_ld = 1'b0;
    chk(cmd_valid == 1'b1, "R6 valid", cmd_valid, 1);
    chk(cmd_code == ec, (code == 4'h2) ? "R7/R8 code" :
        (ec == 4'hF) ? "R9 code" : "R6 code", cmd_code, ec);
    if (ec == 4'h2) chk(toc_sub == sub, "R7 sub", toc_sub, sub);
    @(negedge clk);
    chk(cmd_valid == 1'b0, "R6 valid pulse", cmd_valid, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errs++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1234_5678));
    rst_n = 1'b0; drv_stat_ld = 0; drv_stat = 0; drv_min = 0; drv_sec = 0;
    drv_frm = 0; drv_ext = 0; exp_stb = 0; irq_mask = 0; ctrl_wr = 0;
    ctrl_wdata = 0; cmd_wr = 0; cmd_idx = 0; cmd_nib = 0; imp_stb = 0;
    stat_m = 8'h00; ctrl_m = 8'h00;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(stat_frame == {4'hF, 36'h0}, "R1 frame", stat_frame, {4'hF, 36'h0});
    chk(ctrl_reg == 8'h00, "R1 ctrl", ctrl_reg, 0);
    chk(irq_req == 1'b0, "R1 irq", irq_req, 0);
    chk(cmd_valid == 1'b0, "R1 valid", cmd_valid, 0);
    chk(cmd_code == 4'h0, "R1 code", cmd_code, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(stat_frame == {4'hF, 36'h0}, "R1 frame held", stat_frame, {4'hF, 36'h0});
    // R1 status zero seen via first export; R4 write masked with export
    do_export(1'b1, 1'b1, 8'hFF);
    do_export(1'b0, 1'b0, 8'h00);
    // R4 write without export holds full value
    @(negedge clk); ctrl_wr = 1'b1; ctrl_wdata = 8'hB6; ctrl_m = 8'hB6;
    @(negedge clk); ctrl_wr = 1'b0;
    chk(ctrl_reg == 8'hB6, "R4 plain write", ctrl_reg, 8'hB6);
    do_export(1'b1, 1'b0, 8'h00);
    // R10 plain load, then R6/R9 every code
    do_command(4'h1, 4'h0, 1'b1, 8'hA7);
    do_export(1'b0, 1'b0, 8'h00);
    for (int c = 0; c < 16; c++) begin
      do_command(4'(c), 4'h3, 1'b0, 8'h00);
      do_export(1'b1, 1'b0, 8'h00);
    end
    // R7/R8 all subs
    for (int s = 0; s < 16; s++) begin
      do_command(4'h2, 4'(s), 1'b0, 8'h00);
      do_export(1'b0, 1'b0, 8'h00);
    end
    // R10 load and query together
    do_command(4'h2, 4'h4, 1'b1, 8'h5C);
    do_export(1'b1, 1'b0, 8'h00);
    do_command(4'h2, 4'h9, 1'b1, 8'h33);
    do_export(1'b1, 1'b0, 8'h00);
    // random mix
    for (int k = 0; k < 200; k++) begin
      do_command(4'($urandom), 4'($urandom_range(0, 8)), 1'($urandom),
                 8'($urandom));
      do_export(1'($urandom), 1'($urandom), 8'($urandom));
    end
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule